// File: doc/BRIEF.md
# Dual-Lane Operand Forwarding Unit

This block picks the source of every ALU operand in an in-order pipeline that issues two instructions per cycle. Each of the two execution lanes has two ALU operands, A and B, plus a store-data operand. For each of these the unit decides whether to use the register-file value or a newer result that is still in flight. A result that is still in flight can come from four places: the lane-0 instruction issued in the same cycle, the EX/MEM stage of either lane, the MEM/WB stage of either lane, or a one-cycle-delayed copy of MEM/WB.

The unit receives the full instruction words held in ID/EX, EX/MEM and MEM/WB for both lanes. From each word it decodes the opcode, the source fields and the register that the instruction writes. It registers the MEM/WB words itself to form the delayed copy. Store data can therefore take a value that has just left MEM/WB. The outputs are 3-bit select codes that drive the operand multiplexers in the datapath. The datapath itself lies outside this block.

Top module: `fwd_dual_lane`

## Requirements
- R1: The select code values are 0 register file, 1 lane-0 same-cycle result, 2 EX/MEM lane 0, 3 EX/MEM lane 1, 4 MEM/WB lane 0, 5 MEM/WB lane 1, 6 delayed lane 0, 7 delayed lane 1. When every stage holds a NOP, every select is 0.
- R2: Fields are decoded as opcode at bits 31:26, rs at 25:21, rt at 20:16 and rd at 15:11. Opcode 0x00 (register-register) writes rd. Opcodes 0x0F (load-immediate), 0x08, 0x0C and 0x0D (immediate ALU) and 0x23 (load word) write rt.
- R3: A stage is never chosen as a source when it holds opcode 0x2B (store), 0x04 or 0x05 (branches), 0x02 (jump), 0x3F (NOP) or any other opcode.
- R4: Operand A compares against the consumer's rs. Operand B and store data compare against the consumer's rt.
- R5: For lane 1, the lane-0 instruction in ID/EX is the highest-priority source. Lane 0 never selects code 1.
- R6: A matching EX/MEM producer wins over any matching MEM/WB or delayed producer.
- R7: When both lanes of the same stage match, the lane-1 producer wins.
- R8: Register 0 is forwarded like any other register.
- R9: Only the store-data selects may pick the delayed copy, and only at the lowest forwarding priority. The delayed copy holds the MEM/WB words of the previous cycle. The delayed lane 1 wins over the delayed lane 0.
- R10: When no eligible producer matches, the select is 0.
- R11: Reset clears the delayed copy to NOP, so words held in MEM/WB during reset are never forwarded through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idex_ins0 | input | 32 | Lane-0 instruction in ID/EX (consumer, and same-cycle producer for lane 1) |
| idex_ins1 | input | 32 | Lane-1 instruction in ID/EX (consumer) |
| exmem_ins0 | input | 32 | Lane-0 instruction in EX/MEM |
| exmem_ins1 | input | 32 | Lane-1 instruction in EX/MEM |
| memwb_ins0 | input | 32 | Lane-0 instruction in MEM/WB |
| memwb_ins1 | input | 32 | Lane-1 instruction in MEM/WB |
| l0_sel_a | output | 3 | Lane-0 operand A source |
| l0_sel_b | output | 3 | Lane-0 operand B source |
| l0_sel_st | output | 3 | Lane-0 store-data source |
| l1_sel_a | output | 3 | Lane-1 operand A source |
| l1_sel_b | output | 3 | Lane-1 operand B source |
| l1_sel_st | output | 3 | Lane-1 store-data source |

## Verification
The assertions assume that each stage input carries a complete instruction word and that a bubble shows up as the NOP opcode, not as an undefined value. They do not model load-use stalls. They only check that each select points at a stage whose decoded destination equals the consumer field, and that priority is kept. The stimulus holds register fields to four values, so matches across stages and lanes occur often. It draws opcodes only from the defined writer and non-writer sets. It drives every stage word on each cycle, which keeps the delayed copy fed with known values.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int XLEN    = 32;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;
    localparam int LANES   = 2;
    localparam int NUM_SRC = 7;
    localparam int SEL_W   = 3;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [REG_W-1:0] reg_t;
    typedef logic [OP_W-1:0]  op_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF    = 3'd0,
        SRC_SAME0 = 3'd1,
        SRC_EXM0  = 3'd2,
        SRC_EXM1  = 3'd3,
        SRC_MWB0  = 3'd4,
        SRC_MWB1  = 3'd5,
        SRC_DLY0  = 3'd6,
        SRC_DLY1  = 3'd7
    } src_e;

    typedef struct packed {
        logic wr;
        reg_t dst;
    } prod_t;

    localparam op_t OP_RR   = 6'h00;
    localparam op_t OP_JMP  = 6'h02;
    localparam op_t OP_BEQ  = 6'h04;
    localparam op_t OP_BNE  = 6'h05;
    localparam op_t OP_ADDI = 6'h08;
    localparam op_t OP_ANDI = 6'h0C;
    localparam op_t OP_ORI  = 6'h0D;
    localparam op_t OP_LDI  = 6'h0F;
    localparam op_t OP_LDW  = 6'h23;
    localparam op_t OP_STW  = 6'h2B;
    localparam op_t OP_NOP  = 6'h3F;

    localparam word_t NOP_WORD = {OP_NOP, {(XLEN-OP_W){1'b0}}};

    // slot order is the priority order: 0 highest
    // slots: 0 same0, 1 exm1, 2 exm0, 3 mwb1, 4 mwb0, 5 dly1, 6 dly0
    localparam logic [NUM_SRC-1:0] MASK_L0_OP = 7'b0011110;
    localparam logic [NUM_SRC-1:0] MASK_L1_OP = 7'b0011111;
    localparam logic [NUM_SRC-1:0] MASK_L0_ST = 7'b1111110;
    localparam logic [NUM_SRC-1:0] MASK_L1_ST = 7'b1111111;

    function automatic op_t op_of(input word_t w);
        return w[31:26];
    endfunction

    function automatic reg_t rs_of(input word_t w);
        return w[25:21];
    endfunction

    function automatic reg_t rt_of(input word_t w);
        return w[20:16];
    endfunction

    function automatic reg_t rd_of(input word_t w);
        return w[15:11];
    endfunction

    function automatic logic writes_reg(input word_t w);
        case (op_of(w))
            OP_RR, OP_ADDI, OP_ANDI, OP_ORI, OP_LDI, OP_LDW: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic reg_t dest_of(input word_t w);
        return (op_of(w) == OP_RR) ? rd_of(w) : rt_of(w);
    endfunction

    function automatic src_e slot_code(input int idx);
        case (idx)
            0: return SRC_SAME0;
            1: return SRC_EXM1;
            2: return SRC_EXM0;
            3: return SRC_MWB1;
            4: return SRC_MWB0;
            5: return SRC_DLY1;
            6: return SRC_DLY0;
            default: return SRC_RF;
        endcase
    endfunction
endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
    import fwd_pkg::*;
(
    input  word_t ins,
    output prod_t prod
);
    always_comb begin
        prod.wr  = writes_reg(ins);
        prod.dst = dest_of(ins);
    end
endmodule

// File: rtl/fwd_retire_hold.sv
module fwd_retire_hold
    import fwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t retire_in [LANES],
    output word_t retire_q  [LANES]
);
    for (genvar l = 0; l < LANES; l++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) retire_q[l] <= NOP_WORD;
            else     retire_q[l] <= retire_in[l];
        end
    end
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] EN_MASK = '1
) (
    input  reg_t  want,
    input  prod_t cand [NUM_SRC],
    output src_e  sel
);
    // walk from lowest to highest priority so the youngest match is kept
    always_comb begin
        sel = SRC_RF;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (EN_MASK[i] && cand[i].wr && (cand[i].dst == want))
                sel = slot_code(i);
        end
    end
endmodule

// File: rtl/fwd_dual_lane.sv
module fwd_dual_lane
    import fwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] idex_ins0,
    input  logic [31:0] idex_ins1,
    input  logic [31:0] exmem_ins0,
    input  logic [31:0] exmem_ins1,
    input  logic [31:0] memwb_ins0,
    input  logic [31:0] memwb_ins1,
    output logic [2:0]  l0_sel_a,
    output logic [2:0]  l0_sel_b,
    output logic [2:0]  l0_sel_st,
    output logic [2:0]  l1_sel_a,
    output logic [2:0]  l1_sel_b,
    output logic [2:0]  l1_sel_st
);
    word_t idex_w  [LANES];
    word_t memwb_w [LANES];
    word_t dly_w   [LANES];
    word_t slot_w  [NUM_SRC];
    prod_t cand    [NUM_SRC];
    src_e  sel_a   [LANES];
    src_e  sel_b   [LANES];
    src_e  sel_st  [LANES];

    assign idex_w[0]  = idex_ins0;
    assign idex_w[1]  = idex_ins1;
    assign memwb_w[0] = memwb_ins0;
    assign memwb_w[1] = memwb_ins1;

    fwd_retire_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .retire_in (memwb_w),
        .retire_q  (dly_w)
    );

    assign slot_w[0] = idex_ins0;
    assign slot_w[1] = exmem_ins1;
    assign slot_w[2] = exmem_ins0;
    assign slot_w[3] = memwb_ins1;
    assign slot_w[4] = memwb_ins0;
    assign slot_w[5] = dly_w[1];
    assign slot_w[6] = dly_w[0];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
        fwd_dest_decode u_dec (
            .ins  (slot_w[g]),
            .prod (cand[g])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [NUM_SRC-1:0] OPM = (l == 0) ? MASK_L0_OP : MASK_L1_OP;
        localparam logic [NUM_SRC-1:0] STM = (l == 0) ? MASK_L0_ST : MASK_L1_ST;

        fwd_src_pick #(.EN_MASK(OPM)) u_pick_a (
            .want (rs_of(idex_w[l])),
            .cand (cand),
            .sel  (sel_a[l])
        );
        fwd_src_pick #(.EN_MASK(OPM)) u_pick_b (
            .want (rt_of(idex_w[l])),
            .cand (cand),
            .sel  (sel_b[l])
        );
        fwd_src_pick #(.EN_MASK(STM)) u_pick_st (
            .want (rt_of(idex_w[l])),
            .cand (cand),
            .sel  (sel_st[l])
        );
    end

    assign l0_sel_a  = sel_a[0];
    assign l0_sel_b  = sel_b[0];
    assign l0_sel_st = sel_st[0];
    assign l1_sel_a  = sel_a[1];
    assign l1_sel_b  = sel_b[1];
    assign l1_sel_st = sel_st[1];
endmodule

// File: rtl/fwd_dual_lane_chk.sv
module fwd_dual_lane_chk
    import fwd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] idex_ins0,
    input logic [31:0] idex_ins1,
    input logic [31:0] exmem_ins0,
    input logic [31:0] exmem_ins1,
    input logic [31:0] memwb_ins0,
    input logic [31:0] memwb_ins1,
    input logic [2:0]  l0_sel_a,
    input logic [2:0]  l0_sel_b,
    input logic [2:0]  l0_sel_st,
    input logic [2:0]  l1_sel_a,
    input logic [2:0]  l1_sel_b,
    input logic [2:0]  l1_sel_st
);
    AST_LANE0_NO_SAME: assert property (@(posedge clk) disable iff (rst)
        (l0_sel_a != 3'd1) && (l0_sel_b != 3'd1) && (l0_sel_st != 3'd1)); // R5

    AST_OPERAND_NO_DLY: assert property (@(posedge clk) disable iff (rst)
        (l0_sel_a < 3'd6) && (l0_sel_b < 3'd6) && (l1_sel_a < 3'd6) && (l1_sel_b < 3'd6)); // R9

    AST_SAME_WINS: assert property (@(posedge clk) disable iff (rst)
        (writes_reg(idex_ins0) && dest_of(idex_ins0) == rs_of(idex_ins1)) |-> (l1_sel_a == 3'd1)); // R5

    AST_EXM0_IS_WRITER: assert property (@(posedge clk) disable iff (rst)
        (l0_sel_a == 3'd2) |-> (writes_reg(exmem_ins0) && dest_of(exmem_ins0) == rs_of(idex_ins0))); // R3

    AST_EXM_OVER_MWB: assert property (@(posedge clk) disable iff (rst)
        (writes_reg(exmem_ins0) && dest_of(exmem_ins0) == rs_of(idex_ins0))
        |-> (l0_sel_a == 3'd2 || l0_sel_a == 3'd3)); // R6

    AST_DLY_FROM_PAST: assert property (@(posedge clk) disable iff (rst)
        (l0_sel_st == 3'd7) |-> (writes_reg($past(memwb_ins1)) && dest_of($past(memwb_ins1)) == rt_of(idex_ins0))); // R9

    AST_RF_NO_EXM: assert property (@(posedge clk) disable iff (rst)
        (l1_sel_b == 3'd0) |-> !((writes_reg(exmem_ins1) && dest_of(exmem_ins1) == rt_of(idex_ins1)) ||
                                 (writes_reg(exmem_ins0) && dest_of(exmem_ins0) == rt_of(idex_ins1)))); // R10
endmodule

bind fwd_dual_lane fwd_dual_lane_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .idex_ins0  (idex_ins0),
    .idex_ins1  (idex_ins1),
    .exmem_ins0 (exmem_ins0),
    .exmem_ins1 (exmem_ins1),
    .memwb_ins0 (memwb_ins0),
    .memwb_ins1 (memwb_ins1),
    .l0_sel_a   (l0_sel_a),
    .l0_sel_b   (l0_sel_b),
    .l0_sel_st  (l0_sel_st),
    .l1_sel_a   (l1_sel_a),
    .l1_sel_b   (l1_sel_b),
    .l1_sel_st  (l1_sel_st)
);

// File: tb/fwd_dual_lane_tb.sv
module fwd_dual_lane_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_N    = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] i0, i1, e0, e1, m0, m1;
    logic [2:0]  s0a, s0b, s0s, s1a, s1b, s1s;
    logic [31:0] bd0, bd1;
    logic [31:0] seed = 32'h1234_5678;
    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_dual_lane dut_i (
        .clk(clk), .rst(rst),
        .idex_ins0(i0), .idex_ins1(i1),
        .exmem_ins0(e0), .exmem_ins1(e1),
        .memwb_ins0(m0), .memwb_ins1(m1),
        .l0_sel_a(s0a), .l0_sel_b(s0b), .l0_sel_st(s0s),
        .l1_sel_a(s1a), .l1_sel_b(s1b), .l1_sel_st(s1s)
    );

    localparam logic [31:0] NOPW = 32'hFC00_0000;

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd);
        return {op, rs, rt, rd, 11'd0};
    endfunction

    function automatic logic b_wr(input logic [31:0] w);
        return (w[31:26] == 6'h00) || (w[31:26] == 6'h08) || (w[31:26] == 6'h0C) ||
               (w[31:26] == 6'h0D) || (w[31:26] == 6'h0F) || (w[31:26] == 6'h23);
    endfunction

    function automatic logic hit(input logic [31:0] w, input logic [4:0] a);
        logic [4:0] d;
        d = (w[31:26] == 6'h00) ? w[15:11] : w[20:16];
        return b_wr(w) && (d == a);
    endfunction

    function automatic logic [2:0] model(input int lane, input logic st, input logic [4:0] a);
        if (lane == 1 && hit(i0, a)) return 3'd1;
        if (hit(e1, a)) return 3'd3;
        if (hit(e0, a)) return 3'd2;
        if (hit(m1, a)) return 3'd5;
        if (hit(m0, a)) return 3'd4;
        if (st && hit(bd1, a)) return 3'd7;
        if (st && hit(bd0, a)) return 3'd6;
        return 3'd0;
    endfunction

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a0, a1, x0, x1, w0, w1);
        @(negedge clk);
        bd0 = m0; bd1 = m1;
        i0 = a0; i1 = a1; e0 = x0; e1 = x1; m0 = w0; m1 = w1;
        #(CLK_PERIOD/4);
    endtask

    function automatic logic [5:0] pick_op(input int k);
        case (k)
            0: return 6'h00; 1: return 6'h0F; 2: return 6'h08; 3: return 6'h23;
            4: return 6'h2B; 5: return 6'h04; 6: return 6'h05; 7: return 6'h02;
            8: return 6'h0D; default: return 6'h3F;
        endcase
    endfunction

    function automatic logic [31:0] rnd_word(input logic [31:0] r);
        return mk(pick_op(int'(r[3:0]) % 10), {3'd0, r[5:4]}, {3'd0, r[7:6]}, {3'd0, r[9:8]});
    endfunction

    task automatic step_rng();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w [6];
        i0 = NOPW; i1 = NOPW; e0 = NOPW; e1 = NOPW; m0 = NOPW; m1 = NOPW;
        bd0 = NOPW; bd1 = NOPW;
        repeat (2) @(posedge clk);
        @(negedge clk); #(CLK_PERIOD/4);
        // R1: all NOP -> register file everywhere
        check("R1 l0a", s0a, 3'd0); check("R1 l0b", s0b, 3'd0); check("R1 l0st", s0s, 3'd0);
        check("R1 l1a", s1a, 3'd0); check("R1 l1b", s1b, 3'd0); check("R1 l1st", s1s, 3'd0);

        // R11: load in MEM/WB during reset is not captured by the delayed copy
        @(negedge clk); m1 = mk(6'h23, 5'd1, 5'd6, 5'd0);
        @(negedge clk); rst = 1'b0; m1 = NOPW; i0 = mk(6'h2B, 5'd2, 5'd6, 5'd0);
        #(CLK_PERIOD/4);
        check("R11 store after reset", s0s, 3'd0);

        // R5 R2: rr pair, rd=5 feeds lane1 rs
        apply(mk(6'h00, 5'd1, 5'd2, 5'd5), mk(6'h00, 5'd5, 5'd6, 5'd0), NOPW, NOPW, NOPW, NOPW);
        check("R5 same-cycle", s1a, 3'd1);
        check("R4 rt no match", s1b, 3'd0);
        // R2: load-immediate writes rt, not rd
        apply(mk(6'h0F, 5'd0, 5'd7, 5'd9), mk(6'h00, 5'd9, 5'd7, 5'd0), NOPW, NOPW, NOPW, NOPW);
        check("R2 rd ignored for LI", s1a, 3'd0);
        check("R2 LI rt", s1b, 3'd1);
        check("R2 LI st", s1s, 3'd1);
        // R5: lane0 never takes lane1's same-cycle result
        apply(mk(6'h00, 5'd2, 5'd3, 5'd0), mk(6'h00, 5'd0, 5'd0, 5'd2), NOPW, NOPW, NOPW, NOPW);
        check("R5 lane0 no same", s0a, 3'd0);
        // R3: store in EX/MEM is not a source
        apply(mk(6'h00, 5'd3, 5'd4, 5'd0), NOPW, mk(6'h2B, 5'd1, 5'd3, 5'd3), mk(6'h04, 5'd3, 5'd3, 5'd3),
              mk(6'h02, 5'd3, 5'd3, 5'd3), NOPW);
        check("R3 nonwriter", s0a, 3'd0);
        // R6: EX/MEM over MEM/WB
        apply(mk(6'h00, 5'd4, 5'd1, 5'd0), NOPW, mk(6'h08, 5'd0, 5'd4, 5'd0), NOPW, NOPW, mk(6'h00, 5'd0, 5'd0, 5'd4));
        check("R6 exm over mwb", s0a, 3'd2);
        // R7: lane1 wins inside a stage
        apply(mk(6'h00, 5'd4, 5'd8, 5'd0), NOPW, mk(6'h00, 5'd0, 5'd0, 5'd4), mk(6'h23, 5'd0, 5'd4, 5'd0),
              mk(6'h0F, 5'd0, 5'd8, 5'd0), mk(6'h00, 5'd0, 5'd0, 5'd8));
        check("R7 exm lane1", s0a, 3'd3);
        check("R7 mwb lane1", s0b, 3'd5);
        // R8: register 0 forwards
        apply(mk(6'h00, 5'd0, 5'd9, 5'd0), NOPW, mk(6'h00, 5'd1, 5'd1, 5'd0), NOPW, NOPW, NOPW);
        check("R8 reg0", s0a, 3'd2);
        // R9: delayed copy feeds store data only
        apply(NOPW, NOPW, NOPW, NOPW, NOPW, mk(6'h23, 5'd1, 5'd6, 5'd0));
        apply(mk(6'h2B, 5'd1, 5'd6, 5'd0), NOPW, NOPW, NOPW, NOPW, NOPW);
        check("R9 store dly1", s0s, 3'd7);
        check("R9 operand no dly", s0b, 3'd0);
        // R10: nothing matches
        apply(mk(6'h00, 5'd10, 5'd11, 5'd12), mk(6'h00, 5'd13, 5'd14, 5'd15),
              mk(6'h00, 5'd1, 5'd1, 5'd1), mk(6'h0F, 5'd1, 5'd2, 5'd1), NOPW, NOPW);
        check("R10 l0a", s0a, 3'd0); check("R10 l1b", s1b, 3'd0);

        // sweep: small register space, mixed opcodes
        for (int n = 0; n < SWEEP_N; n++) begin
            for (int k = 0; k < 6; k++) begin
                step_rng();
                w[k] = rnd_word(seed);
            end
            apply(w[0], w[1], w[2], w[3], w[4], w[5]);
            check("R4 R6 R7 l0a",  s0a, model(0, 1'b0, i0[25:21]));
            check("R4 R6 R7 l0b",  s0b, model(0, 1'b0, i0[20:16]));
            check("R9 R3 l0st",    s0s, model(0, 1'b1, i0[20:16]));
            check("R5 R8 l1a",     s1a, model(1, 1'b0, i1[25:21]));
            check("R5 R10 l1b",    s1b, model(1, 1'b0, i1[20:16]));
            check("R9 R2 l1st",    s1s, model(1, 1'b1, i1[20:16]));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule